// File: doc/BRIEF.md
# Pseudo-static RAM power sequencer

This block drives the two chip-select controls of a self-refreshing pseudo-static RAM across three events: the first power-up, entry into deep power-down, and the return from it. It watches a power-good input, a power-down request and a wake request. It drives three things: the active-high chip select 2 line, a force-high override that the memory access controller ORs into chip select 1, and a `mem_ready` flag that tells the access controller when it may start cycles. Every wait is specified in nanoseconds and turned into clock cycles from a clock-period parameter, rounding up.

A power-down request first withdraws `mem_ready` and then waits until the access controller reports idle. It then forces chip select 1 high for a guard interval and only after that drops chip select 2. Chip select 2 stays low for at least its minimum low time. A wake request that arrives inside that window is remembered and served as soon as the window closes. Waking raises chip select 2 and pulses `contents_lost` for one cycle, because refresh stopped while the part was down. Chip select 1 then stays forced high for the full recovery time before `mem_ready` returns. Losing power-good sends the block straight back to its unpowered state from any state.

All pins are plain level control and status signals. No data flows through the block, so it has no valid/ready interface and no back-pressure.

Top module: `psram_pwr_seq`

## Requirements
- R1: During and right after reset, `cs2_out`=0, `cs1_force_hi`=1, `mem_ready`=0 and `contents_lost`=0. These values hold for as long as `pwr_good` stays low.
- R2: One cycle after `pwr_good` is first sampled high, `cs2_out` goes to 1. `cs1_force_hi` stays 1 and `mem_ready` stays 0 for exactly STARTUP cycles, which is STARTUP_NS rounded up to whole clock periods. On the next cycle `mem_ready`=1 and `cs1_force_hi`=0, and `mem_ready` is never 1 unless `cs2_out`=1 and `cs1_force_hi`=0.
- R3: A `pd_req` sampled while ready clears `mem_ready` on the next cycle. `cs2_out` stays 1 and `cs1_force_hi` stays 0 for as long as `ctl_idle` is sampled low.
- R4: Once `ctl_idle` is sampled high, `cs1_force_hi` rises while `cs2_out` is still 1 and stays that way for GUARD_CYC cycles. Only then does `cs2_out` fall. Outside loss of power, `cs2_out` never falls unless `cs1_force_hi` was already 1 in the cycle before.
- R5: Whenever `cs2_out` is 0, `cs1_force_hi` is 1.
- R6: `cs2_out` stays low for at least LOW cycles, which is CS2_LOW_NS rounded up. A wake request first sampled k cycles after the power-down cycle began (k counted from 1) causes the exit after max(LOW, k) cycles of low time.
- R7: Without a wake request, power-down lasts indefinitely.
- R8: On exit, `cs2_out` rises and `contents_lost` is 1 for exactly that one cycle. `cs1_force_hi` stays 1 for WAKE cycles, which is WAKE_NS rounded up, and then `mem_ready` returns.
- R9: `pwr_good` sampled low in any state gives the R1 outputs on the next cycle, with no `contents_lost` pulse.
- R10: `wake_req` has no effect outside power-down and is not remembered: a wake request seen while ready or draining leaves the following power-down waiting for a new wake request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply is up and stable |
| pd_req | input | 1 | Request to enter deep power-down, sampled while ready |
| wake_req | input | 1 | Request to leave deep power-down |
| ctl_idle | input | 1 | Access controller has no cycle in flight |
| cs2_out | output | 1 | Chip select 2 to the memory (high = enabled) |
| cs1_force_hi | output | 1 | Forces chip select 1 high (deselected) |
| mem_ready | output | 1 | Access controller may issue cycles |
| contents_lost | output | 1 | One-cycle pulse on every exit from power-down |

## Verification
The bench sweeps the arrival cycle of a wake request across every cycle of the minimum low window and a few cycles past it. A design that dropped early requests would hang in power-down. A design that served them at once would cut the low time short. A design that counted the window one cycle off would move the exit cycle. The bench times the startup, guard and recovery windows cycle by cycle, so a design that releases chip select 1 or raises `mem_ready` one cycle early is caught. It also delivers wake requests while the block is ready and while it is draining; a block that remembered them would leave power-down by itself. Finally, it removes power-good while ready and while down, and checks that no `contents_lost` pulse leaks out.

// File: rtl/psq_pkg.sv
package psq_pkg;

  typedef enum logic [2:0] {
    ST_NOPWR   = 3'd0,
    ST_STARTUP = 3'd1,
    ST_READY   = 3'd2,
    ST_DRAIN   = 3'd3,
    ST_GUARD   = 3'd4,
    ST_PDOWN   = 3'd5,
    ST_WAKE    = 3'd6
  } psq_state_e;

  // Whole clock cycles covering a time in ns, never less than one.
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                            input int unsigned period_ps);
    longint unsigned num;
    longint unsigned cyc;
    num = longint'(t_ns) * 64'd1000;
    cyc = (num + longint'(period_ps) - 64'd1) / longint'(period_ps);
    if (cyc < 64'd1) cyc = 64'd1;
    return int'(cyc);
  endfunction

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/psq_interval_timer.sv
module psq_interval_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  // Interval timing underlies the R6 low window and the R2/R8 hold windows.
  assert_timer_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

  assert_timer_rest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/psq_wake_hold.sv
module psq_wake_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic in_pdown,
  input  logic wake_req,
  output logic wake_seen
);

  logic pending_q;

  // A request is only kept while the part is down, so nothing seen earlier survives.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b0;
    else        pending_q <= in_pdown && (pending_q || wake_req);
  end

  assign wake_seen = pending_q || wake_req;

  // A pending wake must be traceable to a cycle spent in power-down (R10).
  assert_pending_from_pd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |-> $past(in_pdown));

endmodule

// File: rtl/psq_ctrl.sv
module psq_ctrl
  import psq_pkg::*;
#(
  parameter int unsigned STARTUP_CYC = 4,
  parameter int unsigned WAKE_CYC    = 4,
  parameter int unsigned LOW_CYC     = 2,
  parameter int unsigned GUARD_CYC   = 1,
  parameter int unsigned CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good,
  input  logic             pd_req,
  input  logic             ctl_idle,
  input  logic             wake_seen,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             in_pdown,
  output logic             cs2_o,
  output logic             force_o,
  output logic             ready_o,
  output logic             lost_o
);

  localparam logic [CNT_W-1:0] STARTUP_LD = CNT_W'(STARTUP_CYC - 1);
  localparam logic [CNT_W-1:0] WAKE_LD    = CNT_W'(WAKE_CYC - 1);
  localparam logic [CNT_W-1:0] LOW_LD     = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] GUARD_LD   = CNT_W'(GUARD_CYC - 1);

  psq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!pwr_good) begin
      state_d = ST_NOPWR;
    end else begin
      unique case (state_q)
        ST_NOPWR:   state_d = ST_STARTUP;
        ST_STARTUP: if (tmr_done) state_d = ST_READY;
        ST_READY:   if (pd_req) state_d = ST_DRAIN;
        ST_DRAIN:   if (ctl_idle) state_d = ST_GUARD;
        ST_GUARD:   if (tmr_done) state_d = ST_PDOWN;
        ST_PDOWN:   if (tmr_done && wake_seen) state_d = ST_WAKE;
        ST_WAKE:    if (tmr_done) state_d = ST_READY;
        default:    state_d = ST_NOPWR;
      endcase
    end
  end

  // Each timed state reloads the shared timer as it is entered.
  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      ST_STARTUP: tmr_val = STARTUP_LD;
      ST_GUARD:   tmr_val = GUARD_LD;
      ST_PDOWN:   tmr_val = LOW_LD;
      ST_WAKE:    tmr_val = WAKE_LD;
      default:    tmr_val = '0;
    endcase
  end

  logic cs2_d, force_d, ready_d, lost_d;

  always_comb begin
    cs2_d   = !(state_d == ST_NOPWR || state_d == ST_PDOWN);
    ready_d = (state_d == ST_READY);
    force_d = !(state_d == ST_READY || state_d == ST_DRAIN);
    lost_d  = (state_d == ST_WAKE) && (state_q == ST_PDOWN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_NOPWR;
      cs2_o   <= 1'b0;
      force_o <= 1'b1;
      ready_o <= 1'b0;
      lost_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      cs2_o   <= cs2_d;
      force_o <= force_d;
      ready_o <= ready_d;
      lost_o  <= lost_d;
    end
  end

  assign in_pdown = (state_q == ST_PDOWN);

  // Length of the current run of low chip select 2, saturating at LOW_CYC.
  logic [CNT_W-1:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         low_run_q <= '0;
    else if (cs2_o)                     low_run_q <= '0;
    else if (low_run_q != LOW_LD + 1'b1) low_run_q <= low_run_q + 1'b1;
  end

  assert_ready_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (cs2_o && !force_o));

  assert_fall_guarded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs2_o) && $past(pwr_good)) |-> $past(force_o));

  assert_low_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs2_o |-> force_o);

  assert_low_long_enough_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |-> (low_run_q == LOW_LD + 1'b1));

  assert_lost_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |-> ($rose(cs2_o) && force_o));

  assert_lost_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |=> !lost_o);

  assert_power_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!cs2_o && force_o && !ready_o && !lost_o));

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 5000,
  parameter int unsigned STARTUP_NS    = 300000,
  parameter int unsigned WAKE_NS       = 300000,
  parameter int unsigned CS2_LOW_NS    = 30,
  parameter int unsigned GUARD_CYC     = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic pd_req,
  input  logic wake_req,
  input  logic ctl_idle,
  output logic cs2_out,
  output logic cs1_force_hi,
  output logic mem_ready,
  output logic contents_lost
);

  localparam int unsigned STARTUP_CYC = ns_to_cyc(STARTUP_NS, CLK_PERIOD_PS);
  localparam int unsigned WAKE_CYC    = ns_to_cyc(WAKE_NS, CLK_PERIOD_PS);
  localparam int unsigned LOW_CYC     = ns_to_cyc(CS2_LOW_NS, CLK_PERIOD_PS);
  localparam int unsigned GUARD_EFF   = (GUARD_CYC < 1) ? 1 : GUARD_CYC;
  localparam int unsigned MAX_CYC     = max_of4(STARTUP_CYC, WAKE_CYC, LOW_CYC, GUARD_EFF);
  localparam int unsigned CNT_W       = $clog2(MAX_CYC + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             in_pdown;
  logic             wake_seen;

  psq_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  psq_wake_hold u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_pdown  (in_pdown),
    .wake_req  (wake_req),
    .wake_seen (wake_seen)
  );

  psq_ctrl #(
    .STARTUP_CYC (STARTUP_CYC),
    .WAKE_CYC    (WAKE_CYC),
    .LOW_CYC     (LOW_CYC),
    .GUARD_CYC   (GUARD_EFF),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_good  (pwr_good),
    .pd_req    (pd_req),
    .ctl_idle  (ctl_idle),
    .wake_seen (wake_seen),
    .tmr_done  (tmr_done),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .in_pdown  (in_pdown),
    .cs2_o     (cs2_out),
    .force_o   (cs1_force_hi),
    .ready_o   (mem_ready),
    .lost_o    (contents_lost)
  );

endmodule

// File: tb/psram_pwr_seq_tb.sv
module psram_pwr_seq_tb;

  localparam int unsigned PER_PS  = 5000;
  localparam int unsigned ST_NS   = 100;
  localparam int unsigned WK_NS   = 60;
  localparam int unsigned LO_NS   = 30;
  localparam int unsigned GUARD   = 2;
  // Expected cycle counts: ceiling of ns*1000/period.
  localparam int STARTUP = (ST_NS * 1000 + PER_PS - 1) / PER_PS;
  localparam int WAKE    = (WK_NS * 1000 + PER_PS - 1) / PER_PS;
  localparam int LOW     = (LO_NS * 1000 + PER_PS - 1) / PER_PS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0, pd_req = 1'b0, wake_req = 1'b0, ctl_idle = 1'b0;
  logic cs2_out, cs1_force_hi, mem_ready, contents_lost;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  psram_pwr_seq #(
    .CLK_PERIOD_PS (PER_PS),
    .STARTUP_NS    (ST_NS),
    .WAKE_NS       (WK_NS),
    .CS2_LOW_NS    (LO_NS),
    .GUARD_CYC     (GUARD)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .pwr_good (pwr_good), .pd_req (pd_req),
    .wake_req (wake_req), .ctl_idle (ctl_idle), .cs2_out (cs2_out),
    .cs1_force_hi (cs1_force_hi), .mem_ready (mem_ready),
    .contents_lost (contents_lost)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Expected vector is {cs2, force, ready, lost}.
  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] got;
    got = {cs2_out, cs1_force_hi, mem_ready, contents_lost};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got cs2/force/ready/lost=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic power_up();
    pwr_good = 1'b1;
    for (int i = 0; i < STARTUP; i++) begin
      step();
      chk("R2 startup hold", 4'b1100);
    end
    step();
    chk("R2 ready after startup", 4'b1010);
  endtask

  // Leaves the block one sample into power-down.
  task automatic enter_pd(input int idle_wait);
    pd_req = 1'b1;
    ctl_idle = 1'b0;
    step();
    chk("R3 drain entry", 4'b1000);
    pd_req = 1'b0;
    for (int i = 0; i < idle_wait; i++) begin
      step();
      chk("R3 drain wait", 4'b1000);
    end
    ctl_idle = 1'b1;
    for (int i = 0; i < GUARD; i++) begin
      step();
      chk("R4 guard", 4'b1100);
    end
    step();
    chk("R5 cs2 low with force", 4'b0100);
    ctl_idle = 1'b0;
  endtask

  task automatic recover();
    for (int i = 1; i < WAKE; i++) begin
      step();
      chk("R8 recovery hold", 4'b1100);
    end
    step();
    chk("R8 ready after recovery", 4'b1010);
  endtask

  initial begin
    repeat (3) step();
    chk("R1 in reset", 4'b0100);
    rst_n = 1'b1;
    repeat (4) begin
      step();
      chk("R1 unpowered", 4'b0100);
    end

    power_up();

    // R6: sweep the wake arrival across and beyond the low window.
    for (int k = 0; k <= LOW + 2; k++) begin
      int ex;
      ex = (k + 1 > LOW) ? k + 1 : LOW;
      enter_pd(k % 3);
      for (int idx = 1; idx <= ex; idx++) begin
        wake_req = (idx - 1 == k);
        step();
        if (idx < ex) chk("R6 held low", 4'b0100);
        else          chk("R6 exit with R8 lost pulse", 4'b1101);
      end
      wake_req = 1'b0;
      recover();
    end

    // R7: no wake, no exit.
    enter_pd(0);
    for (int i = 0; i < 40; i++) begin
      step();
      chk("R7 stays down", 4'b0100);
    end
    wake_req = 1'b1;
    step();
    chk("R7 late wake exits", 4'b1101);
    wake_req = 1'b0;
    recover();

    // R10: wake while ready and while draining leaves no trace.
    wake_req = 1'b1;
    step();
    chk("R10 wake ignored when ready", 4'b1010);
    pd_req = 1'b1;
    step();
    chk("R10 drain with wake", 4'b1000);
    pd_req = 1'b0;
    step();
    chk("R10 drain with wake", 4'b1000);
    wake_req = 1'b0;
    ctl_idle = 1'b1;
    for (int i = 0; i < GUARD; i++) begin
      step();
      chk("R4 guard", 4'b1100);
    end
    step();
    chk("R5 down", 4'b0100);
    ctl_idle = 1'b0;
    for (int i = 0; i < LOW + 3; i++) begin
      step();
      chk("R10 no remembered wake", 4'b0100);
    end
    wake_req = 1'b1;
    step();
    chk("R10 fresh wake exits", 4'b1101);
    wake_req = 1'b0;
    recover();

    // R9: power loss while ready, then while down.
    pwr_good = 1'b0;
    step();
    chk("R9 loss when ready", 4'b0100);
    step();
    chk("R9 stays unpowered", 4'b0100);
    power_up();
    enter_pd(1);
    step();
    pwr_good = 1'b0;
    wake_req = 1'b1;
    step();
    chk("R9 loss when down, no lost pulse", 4'b0100);
    wake_req = 1'b0;
    step();
    chk("R9 stays unpowered", 4'b0100);
    power_up();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule